// File: doc/BRIEF.md
# Memory Access Permission Checker

This block judges a single memory access against a bank of protection entries and returns one grant or deny verdict. Each access is described by its start address, its length in bytes, the read, write and execute rights it asks for, and the privilege mode of the requester. Every entry arrives already decoded from outside: an enable, a lock flag, three permission bits, and an inclusive lower and upper byte bound. The configuration store and the decoding of raw settings into bounds sit in neighbouring blocks, which drive these inputs.

Entries are scanned by fixed priority, lowest index first. The first enabled entry that the access touches at either its first or its last byte decides the outcome. The checker reports whether an entry decided, and which one. A parameter selects either a purely combinational verdict or a registered verdict with one cycle of latency.

Top module: `pmp_perm_check`

## Requirements
- R1: When no entry is enabled, `grant` is 1 only for machine mode (`cur_mode` = 3), and `hit` is 0.
- R2: Enabled entries are examined from index 0 upward. The lowest-indexed enabled entry that holds the first byte or the last byte of the access decides the verdict, and `hit_idx` reports that index.
- R3: If an enabled entry holds exactly one of the first byte and the last byte (`acc_addr + size - 1`, modulo 2^ADDR_W), the access is denied, with `hit` = 1.
- R4: If an enabled entry holds both bytes, that entry decides, and entries with higher indices have no effect.
- R5: Machine mode on a deciding entry that is not locked may use read, write and execute, whatever the entry's permission bits are.
- R6: User mode (0), supervisor mode (1), the reserved value 2, and any mode on a locked entry are limited to the entry's permission bits: bit 0 read, bit 1 write, bit 2 execute (three bits per entry in `ent_perm`).
- R7: A deciding entry grants only when every requested right is among the allowed rights. A request for no rights is granted.
- R8: When entries are enabled but none is touched, machine mode is granted, every other mode is denied, and `hit` is 0.
- R9: An `acc_size` of 0 is treated as one machine word of XLEN/8 bytes.
- R10: Both bounds of an entry are inclusive.
- R11: With REG_OUT = 1, the verdict appears one clock after its inputs. During reset `grant`, `hit` and `hit_idx` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_addr | input | ADDR_W | Byte address of the first byte of the access |
| acc_size | input | SIZE_W | Access length in bytes; 0 means one word |
| acc_rd | input | 1 | Read right requested |
| acc_wr | input | 1 | Write right requested |
| acc_ex | input | 1 | Execute right requested |
| cur_mode | input | 2 | Privilege mode: 0 user, 1 supervisor, 3 machine |
| ent_on | input | N_ENTRIES | Per-entry enable |
| ent_lock | input | N_ENTRIES | Per-entry lock flag |
| ent_perm | input | 3*N_ENTRIES | Per-entry rights, {X,W,R} for entry i at bits 3i+2..3i |
| ent_lo | input | ADDR_W*N_ENTRIES | Per-entry inclusive lower byte bound |
| ent_hi | input | ADDR_W*N_ENTRIES | Per-entry inclusive upper byte bound |
| grant | output | 1 | Access permitted |
| hit | output | 1 | An entry decided the verdict |
| hit_idx | output | IDX_W | Index of the deciding entry |

## Verification
The hardest case to reach from the ports is an access that straddles an entry boundary while a lower-priority entry fully covers it. The partial overlap on the higher-priority entry must win and deny, even for machine mode. Random entry bounds drawn from a narrow address window, together with access lengths up to a dozen bytes, make such straddles and overlapping entries common. Directed cases then place accesses exactly on the inclusive bounds, wrap the last byte, and use a zero size.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;
   typedef enum logic [1:0] {
      MODE_USR = 2'd0,
      MODE_SUP = 2'd1,
      MODE_RSV = 2'd2,
      MODE_MCH = 2'd3
   } priv_mode_e;

   localparam int RIGHT_R = 0;
   localparam int RIGHT_W = 1;
   localparam int RIGHT_X = 2;
   localparam int RIGHTS_W = 3;
endpackage

// File: rtl/pmp_span_match.sv
module pmp_span_match #(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] lo_b,
   input  logic [ADDR_W-1:0] hi_b,
   input  logic [ADDR_W-1:0] first_b,
   input  logic [ADDR_W-1:0] last_b,
   input  logic              en,
   output logic              covers,
   output logic              straddles
);
   logic first_in, last_in;

   always_comb begin
      first_in  = (first_b >= lo_b) && (first_b <= hi_b);
      last_in   = (last_b >= lo_b) && (last_b <= hi_b);
      covers    = en && first_in && last_in;
      straddles = en && (first_in ^ last_in);
   end
endmodule

// File: rtl/pmp_first_pick.sv
module pmp_first_pick #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     cand,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      found = |cand;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (cand[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/pmp_rights_eval.sv
module pmp_rights_eval
   import pmp_chk_pkg::*;
(
   input  priv_mode_e          mode,
   input  logic                locked,
   input  logic [RIGHTS_W-1:0] ent_rights,
   input  logic [RIGHTS_W-1:0] want,
   input  logic                partial,
   output logic                ok
);
   logic [RIGHTS_W-1:0] allow;

   always_comb begin
      if (mode == MODE_MCH && !locked) allow = '1;
      else                             allow = ent_rights;
      ok = !partial && ((want & ~allow) == '0);
   end
endmodule

// File: rtl/pmp_perm_check.sv
module pmp_perm_check
   import pmp_chk_pkg::*;
#(
   parameter int N_ENTRIES = 8,
   parameter int ADDR_W    = 32,
   parameter int SIZE_W    = 8,
   parameter int XLEN      = 32,
   parameter bit REG_OUT   = 1'b1,
   localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             acc_addr,
   input  logic [SIZE_W-1:0]             acc_size,
   input  logic                          acc_rd,
   input  logic                          acc_wr,
   input  logic                          acc_ex,
   input  logic [1:0]                    cur_mode,
   input  logic [N_ENTRIES-1:0]          ent_on,
   input  logic [N_ENTRIES-1:0]          ent_lock,
   input  logic [RIGHTS_W*N_ENTRIES-1:0] ent_perm,
   input  logic [ADDR_W*N_ENTRIES-1:0]   ent_lo,
   input  logic [ADDR_W*N_ENTRIES-1:0]   ent_hi,
   output logic                          grant,
   output logic                          hit,
   output logic [IDX_W-1:0]              hit_idx
);
   localparam int WORD_BYTES = XLEN / 8;

   if (N_ENTRIES < 1) begin : g_bad_n
      $error("N_ENTRIES must be at least 1");
   end
   if (XLEN % 8 != 0 || XLEN < 8) begin : g_bad_xlen
      $error("XLEN must be a positive multiple of 8");
   end
   if (WORD_BYTES >= (1 << SIZE_W)) begin : g_bad_size
      $error("SIZE_W too narrow for one machine word");
   end
   if (SIZE_W > ADDR_W) begin : g_bad_sw
      $error("SIZE_W must not exceed ADDR_W");
   end

   logic [SIZE_W-1:0]    eff_size;
   logic [ADDR_W-1:0]    last_b;
   logic [N_ENTRIES-1:0] cov, strad, cand;

   always_comb begin
      eff_size = (acc_size == '0) ? SIZE_W'(WORD_BYTES) : acc_size;
      last_b   = acc_addr + ADDR_W'(eff_size) - ADDR_W'(1);
   end

   for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
      pmp_span_match #(.ADDR_W(ADDR_W)) u_span (
         .lo_b      (ent_lo[g*ADDR_W +: ADDR_W]),
         .hi_b      (ent_hi[g*ADDR_W +: ADDR_W]),
         .first_b   (acc_addr),
         .last_b    (last_b),
         .en        (ent_on[g]),
         .covers    (cov[g]),
         .straddles (strad[g])
      );
      assign cand[g] = cov[g] | strad[g];
   end

   logic             found;
   logic [IDX_W-1:0] pick;

   pmp_first_pick #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_pick (
      .cand  (cand),
      .found (found),
      .idx   (pick)
   );

   priv_mode_e          mode_e;
   logic [RIGHTS_W-1:0] want, sel_rights;
   logic                sel_lock, sel_strad, ent_ok;

   always_comb begin
      mode_e     = priv_mode_e'(cur_mode);
      want       = {acc_ex, acc_wr, acc_rd};
      sel_rights = ent_perm[32'(pick)*RIGHTS_W +: RIGHTS_W];
      sel_lock   = ent_lock[pick];
      sel_strad  = strad[pick];
   end

   pmp_rights_eval u_eval (
      .mode       (mode_e),
      .locked     (sel_lock),
      .ent_rights (sel_rights),
      .want       (want),
      .partial    (sel_strad),
      .ok         (ent_ok)
   );

   logic             v_grant, v_hit;
   logic [IDX_W-1:0] v_idx;

   always_comb begin
      v_hit   = found;
      v_idx   = found ? pick : '0;
      v_grant = found ? ent_ok : (mode_e == MODE_MCH);
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            grant   <= 1'b0;
            hit     <= 1'b0;
            hit_idx <= '0;
         end else begin
            grant   <= v_grant;
            hit     <= v_hit;
            hit_idx <= v_idx;
         end
      end
   end else begin : g_comb
      always_comb begin
         grant   = v_grant;
         hit     = v_hit;
         hit_idx = v_idx;
      end
   end
endmodule

// File: rtl/pmp_perm_check_sva.sv
module pmp_perm_check_sva #(
   parameter int N_ENTRIES = 8,
   parameter bit REG_OUT   = 1'b1,
   parameter int IDX_W     = 3
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   acc_rd,
   input logic                   acc_wr,
   input logic                   acc_ex,
   input logic [1:0]             cur_mode,
   input logic [N_ENTRIES-1:0]   ent_on,
   input logic [N_ENTRIES-1:0]   ent_lock,
   input logic [3*N_ENTRIES-1:0] ent_perm,
   input logic                   grant,
   input logic                   hit,
   input logic [IDX_W-1:0]       hit_idx
);
   logic [N_ENTRIES-1:0]   on_q, lock_q;
   logic [3*N_ENTRIES-1:0] perm_q;
   logic [1:0]             mode_q;
   logic [2:0]             req_q;

   if (REG_OUT) begin : g_q
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            on_q <= '0; lock_q <= '0; perm_q <= '0; mode_q <= '0; req_q <= '0;
         end else begin
            on_q   <= ent_on;
            lock_q <= ent_lock;
            perm_q <= ent_perm;
            mode_q <= cur_mode;
            req_q  <= {acc_ex, acc_wr, acc_rd};
         end
      end
   end else begin : g_d
      always_comb begin
         on_q = ent_on; lock_q = ent_lock; perm_q = ent_perm;
         mode_q = cur_mode; req_q = {acc_ex, acc_wr, acc_rd};
      end
   end

   a_r1_no_rules: assert property (@(posedge clk) disable iff (!rst_n)
      (on_q == '0) |-> (!hit && (grant == (mode_q == 2'd3))));

   a_r8_no_match: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (grant == (mode_q == 2'd3)));

   a_r2_hit_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> on_q[hit_idx]);

   a_r6_limited: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && grant && (mode_q != 2'd3 || lock_q[hit_idx]))
         |-> ((req_q & ~perm_q[32'(hit_idx)*3 +: 3]) == 3'b000));

   a_r11_idx_zero_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (hit_idx == '0));
endmodule

bind pmp_perm_check pmp_perm_check_sva #(
   .N_ENTRIES (N_ENTRIES),
   .REG_OUT   (REG_OUT),
   .IDX_W     (IDX_W)
) u_sva (
   .clk      (clk),
   .rst_n    (rst_n),
   .acc_rd   (acc_rd),
   .acc_wr   (acc_wr),
   .acc_ex   (acc_ex),
   .cur_mode (cur_mode),
   .ent_on   (ent_on),
   .ent_lock (ent_lock),
   .ent_perm (ent_perm),
   .grant    (grant),
   .hit      (hit),
   .hit_idx  (hit_idx)
);

// File: tb/pmp_perm_check_tb.sv
module pmp_perm_check_tb;
   localparam int N  = 8;
   localparam int AW = 32;
   localparam int SW = 8;
   localparam int IW = 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [AW-1:0]  acc_addr = '0;
   logic [SW-1:0]  acc_size = '0;
   logic           acc_rd = 1'b0, acc_wr = 1'b0, acc_ex = 1'b0;
   logic [1:0]     cur_mode = 2'd0;
   logic [N-1:0]   ent_on = '0, ent_lock = '0;
   logic [3*N-1:0] ent_perm = '0;
   logic [AW*N-1:0] ent_lo = '0, ent_hi = '0;
   logic           grant, hit;
   logic [IW-1:0]  hit_idx;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   pmp_perm_check #(.N_ENTRIES(N), .ADDR_W(AW), .SIZE_W(SW), .XLEN(32), .REG_OUT(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_size(acc_size),
      .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_ex(acc_ex), .cur_mode(cur_mode),
      .ent_on(ent_on), .ent_lock(ent_lock), .ent_perm(ent_perm),
      .ent_lo(ent_lo), .ent_hi(ent_hi),
      .grant(grant), .hit(hit), .hit_idx(hit_idx)
   );

   function automatic logic [IW+1:0] model();
      logic [AW-1:0] last;
      logic [SW-1:0] sz;
      logic [2:0] want, allow;
      sz = (acc_size == 0) ? SW'(4) : acc_size;
      last = acc_addr + AW'(sz) - 1;
      want = {acc_ex, acc_wr, acc_rd};
      for (int i = 0; i < N; i++) begin
         logic [AW-1:0] lo, hi;
         logic fi, la;
         lo = ent_lo[i*AW +: AW];
         hi = ent_hi[i*AW +: AW];
         fi = acc_addr >= lo && acc_addr <= hi;
         la = last >= lo && last <= hi;
         if (ent_on[i] && (fi || la)) begin
            if (fi != la) return {1'b0, 1'b1, IW'(i)};
            allow = (cur_mode == 2'd3 && !ent_lock[i]) ? 3'b111 : ent_perm[i*3 +: 3];
            return {((want & ~allow) == 3'b000), 1'b1, IW'(i)};
         end
      end
      return {(cur_mode == 2'd3), 1'b0, IW'(0)};
   endfunction

   task automatic check(input string req, input logic [IW+1:0] exp);
      checks++;
      if ({grant, hit, hit_idx} !== exp) begin
         errors++;
         $display("FAIL %s: got grant=%0b hit=%0b idx=%0d expected grant=%0b hit=%0b idx=%0d",
                  req, grant, hit, hit_idx, exp[IW+1], exp[IW], exp[IW-1:0]);
      end
   endtask

   task automatic run(input string req);
      logic [IW+1:0] exp;
      exp = model();
      @(negedge clk);
      check(req, exp);
   endtask

   task automatic set_ent(input int i, input logic on, input logic lk, input logic [2:0] pm,
                          input logic [AW-1:0] lo, input logic [AW-1:0] hi);
      ent_on[i] = on; ent_lock[i] = lk; ent_perm[i*3 +: 3] = pm;
      ent_lo[i*AW +: AW] = lo; ent_hi[i*AW +: AW] = hi;
   endtask

   task automatic acc(input logic [AW-1:0] a, input logic [SW-1:0] s, input logic [2:0] w, input logic [1:0] m);
      acc_addr = a; acc_size = s; {acc_ex, acc_wr, acc_rd} = w; cur_mode = m;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'd20240611);
      acc(32'h100, 4, 3'b111, 2'd3);
      @(negedge clk);
      check("R11 reset", {1'b0, 1'b0, IW'(0)});
      rst_n = 1'b1;
      @(negedge clk);

      // R1: no entries enabled
      acc(32'h40, 4, 3'b001, 2'd3); run("R1 machine");
      acc(32'h40, 4, 3'b001, 2'd1); run("R1 supervisor");
      acc(32'h40, 4, 3'b000, 2'd0); run("R1 user");

      // R8: entries exist, no match
      set_ent(2, 1, 0, 3'b111, 32'h1000, 32'h10FF);
      acc(32'h40, 4, 3'b011, 2'd3); run("R8 machine miss");
      acc(32'h40, 4, 3'b001, 2'd0); run("R8 user miss");

      // R4 R7 R6: full cover, user rights
      set_ent(2, 1, 0, 3'b001, 32'h1000, 32'h10FF);
      acc(32'h1010, 4, 3'b001, 2'd0); run("R4 R7 user read ok");
      acc(32'h1010, 4, 3'b011, 2'd0); run("R7 user write denied");
      acc(32'h1010, 4, 3'b000, 2'd1); run("R7 empty request");
      acc(32'h1010, 4, 3'b100, 2'd2); run("R6 reserved mode limited");

      // R5 / R6 locked
      acc(32'h1010, 4, 3'b111, 2'd3); run("R5 machine unlocked all");
      set_ent(2, 1, 1, 3'b001, 32'h1000, 32'h10FF);
      acc(32'h1010, 4, 3'b010, 2'd3); run("R6 machine locked write denied");
      acc(32'h1010, 4, 3'b001, 2'd3); run("R6 machine locked read ok");

      // R10 inclusive bounds
      acc(32'h1000, 1, 3'b001, 2'd0); run("R10 low bound");
      acc(32'h10FC, 4, 3'b001, 2'd0); run("R10 high bound");

      // R3 straddle, overrides a covering lower-priority entry
      set_ent(5, 1, 0, 3'b111, 32'h0F00, 32'h1FFF);
      acc(32'h10FE, 4, 3'b001, 2'd3); run("R3 straddle high");
      acc(32'h0FFE, 4, 3'b000, 2'd3); run("R3 straddle low");

      // R2 priority
      set_ent(2, 0, 0, 3'b000, 32'h1000, 32'h10FF);
      set_ent(1, 1, 0, 3'b000, 32'h1000, 32'h17FF);
      acc(32'h1200, 8, 3'b001, 2'd1); run("R2 lowest index decides deny");
      set_ent(1, 0, 0, 3'b000, 32'h0, 32'h0);
      acc(32'h1200, 8, 3'b001, 2'd1); run("R2 next entry decides");

      // R9 size zero = 4 bytes
      set_ent(5, 1, 0, 3'b111, 32'h2000, 32'h2003);
      acc(32'h2000, 0, 3'b001, 2'd0); run("R9 zero size fits");
      acc(32'h2001, 0, 3'b001, 2'd0); run("R9 zero size straddles");

      // R3 wraparound of last byte
      set_ent(0, 1, 0, 3'b111, 32'hFFFF_FFF0, 32'hFFFF_FFFF);
      acc(32'hFFFF_FFFE, 4, 3'b001, 2'd0); run("R3 wrap straddle");

      // random: R2 R3 R4 R6 R7 R8
      for (int k = 0; k < 600; k++) begin
         for (int i = 0; i < N; i++) begin
            logic [AW-1:0] lo;
            lo = AW'($urandom % 256);
            set_ent(i, 1'($urandom), 1'($urandom), 3'($urandom), lo, lo + AW'($urandom % 40));
         end
         begin
            logic [1:0] m;
            m = 2'($urandom % 4);
            acc(AW'($urandom % 320), SW'($urandom % 13), 3'($urandom), m);
         end
         run("R2 R3 R4 R7 random");
      end

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule